// File: doc/BRIEF.md
# Multi-Line Transmit DMA Scheduler

This block feeds the transmit side of a bank of serial lines directly from memory. Software reaches every line through one small register window. A select field in the control register picks the line, and the address and count registers in the window then refer to that line. Software loads a start address and a byte count, where the count is the two's-complement negative of the number of bytes. It then starts the line by setting that line's bit in the active register.

A round-robin fetch engine serves the active lines one byte at a time over a valid/ready memory read port. It fetches for a line only when that line's serialiser can take another byte. After each byte it steps the line's 18-bit address and moves the count one step toward zero. When the count reaches zero, the hardware clears the line's active bit and sets a sticky transmit-done flag, which can raise an interrupt. A fetch that gets no answer sets a sticky memory-error flag and ends that line. A per-line break register holds selected outputs in the spacing state.

Top module: `mux_txdma`

## Requirements
- R1: After reset, every readable register reads 0. `irq`, `mem_req_valid`, `tx_load` and `tx_break` are all 0.
- R2: Register offsets are control = 0, address = 1, count = 2, active = 3 and break = 4. Control bits 3:0 pick the line that offsets 1 and 2 read and write. The other lines keep their values.
- R3: Writing the control register stores bits 5:4 as the high address bits of the line named in bits 3:0. A control read returns those bits for the selected line. The fetch address is {high bits, address register}, and each step carries from bit 15 into bit 16.
- R4: For each byte of an active line, the engine requests the current 18-bit address. It presents the returned byte on `tx_data` with a one-cycle pulse on that line's `tx_load` bit. It then adds 1 to the address and adds 1 to the count.
- R5: When a line's count reaches 0 after a byte, its active bit clears and control bit 15 (transmit done) is set.
- R6: `irq` is high exactly when control bit 15 and control bit 13 (interrupt enable) are both set.
- R7: Writing control with bit 15 = 0 clears the done flag, and writing it as 1 leaves the flag unchanged. A hardware set in the same cycle wins over a clear.
- R8: At most one fetch is outstanding. Eligible lines are served in rotating order after the last line served. A line whose `tx_empty` input is low gets no fetch.
- R9: Writing a count of 0xFFFF to a line that is already running ends it after exactly one more byte. The address register then shows how many bytes were sent.
- R10: Writing the active register sets each line whose data bit is 1. Zero bits have no effect, because only the hardware clears active bits.
- R11: A line made active while its count is 0 finishes at once, with no fetch. Its active bit clears and the done flag is set.
- R12: A fetch that gets no response within TOUT cycles sets control bit 10 (memory error). It also clears the line's active bit, sets the done flag and leaves that line's address and count unchanged. Writing 1 to control bit 8 clears bit 10, and a new error in the same cycle wins.
- R13: Each bit of the break register drives the matching `tx_break` output directly, and the register reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 18 | Byte address of the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data byte |
| tx_empty | input | 16 | Per-line serialiser can accept a byte |
| tx_load | output | 16 | Per-line byte strobe |
| tx_data | output | 8 | Byte for the strobed line |
| tx_break | output | 16 | Per-line hold-in-spacing control |
| irq | output | 1 | Transmit-done interrupt |

## Verification
On every cycle, the bound assertions check the following: the byte strobes stay one-hot or zero and only reach active lines, a request holds its address until it is accepted, the done and memory-error flags stay set until their own clear writes, the interrupt implies the done flag, and no request appears while no line is active. Other behaviour shows only over the bench's scenarios:
- the rotating service order
- holding off a line whose serialiser is full
- the stop-after-one-more-byte effect of a 0xFFFF count
- the carry into the high address bits
- immediate completion on a zero count
- the timeout path that leaves address and count untouched

A per-line scoreboard of expected bytes checks that every byte reaches the right line with the right data.

// File: rtl/txd_pkg.sv
`timescale 1ns/1ps
package txd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } eng_st_e;

    localparam logic [2:0] OFS_CTL = 3'd0;
    localparam logic [2:0] OFS_ADR = 3'd1;
    localparam logic [2:0] OFS_CNT = 3'd2;
    localparam logic [2:0] OFS_ACT = 3'd3;
    localparam logic [2:0] OFS_BRK = 3'd4;

    localparam int CB_DONE = 15;
    localparam int CB_IEN  = 13;
    localparam int CB_MERR = 10;
    localparam int CB_MCLR = 8;
    localparam int CB_EXT  = 4;
endpackage

// File: rtl/txd_rr_pick.sv
`timescale 1ns/1ps
module txd_rr_pick #(
    parameter int N  = 16,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [LW-1:0] last,
    output logic          any,
    output logic [LW-1:0] idx
);
    int j;
    always_comb begin
        any = 1'b0;
        idx = last;
        j   = 0;
        for (int k = 1; k <= N; k++) begin
            j = (int'(last) + k) % N;
            if (!any && req[j]) begin
                any = 1'b1;
                idx = LW'(j);
            end
        end
    end
endmodule

// File: rtl/txd_line_bank.sv
`timescale 1ns/1ps
module txd_line_bank #(
    parameter int N  = 16,
    parameter int LW = $clog2(N),
    parameter int AW = 16,
    parameter int XW = 2,
    parameter int CW = 16,
    localparam int FW = AW + XW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] sw_sel,
    input  logic          sw_we_adr,
    input  logic [AW-1:0] sw_adr,
    input  logic          sw_we_cnt,
    input  logic [CW-1:0] sw_cnt,
    input  logic          sw_we_ext,
    input  logic [LW-1:0] sw_ext_idx,
    input  logic [XW-1:0] sw_ext,
    input  logic          hw_upd,
    input  logic [LW-1:0] hw_idx,
    input  logic [FW-1:0] hw_adr,
    input  logic [CW-1:0] hw_cnt,
    output logic [AW-1:0] sel_adr,
    output logic [CW-1:0] sel_cnt,
    output logic [XW-1:0] sel_ext,
    output logic [FW-1:0] eng_adr,
    output logic [CW-1:0] eng_cnt,
    output logic [N-1:0]  cnt_zero
);
    typedef struct packed {
        logic [N-1:0][AW-1:0] adr;
        logic [N-1:0][XW-1:0] ext;
        logic [N-1:0][CW-1:0] cnt;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (hw_upd) begin
            {bank_d.ext[hw_idx], bank_d.adr[hw_idx]} = hw_adr;
            bank_d.cnt[hw_idx] = hw_cnt;
        end
        // software writes override an engine update of the same field
        if (sw_we_adr) bank_d.adr[sw_sel]     = sw_adr;
        if (sw_we_cnt) bank_d.cnt[sw_sel]     = sw_cnt;
        if (sw_we_ext) bank_d.ext[sw_ext_idx] = sw_ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign sel_adr = bank_q.adr[sw_sel];
    assign sel_cnt = bank_q.cnt[sw_sel];
    assign sel_ext = bank_q.ext[sw_sel];
    assign eng_adr = {bank_q.ext[hw_idx], bank_q.adr[hw_idx]};
    assign eng_cnt = bank_q.cnt[hw_idx];

    for (genvar g = 0; g < N; g++) begin : g_zero
        assign cnt_zero[g] = (bank_q.cnt[g] == '0);
    end
endmodule

// File: rtl/txd_fetch_engine.sv
`timescale 1ns/1ps
module txd_fetch_engine
    import txd_pkg::*;
#(
    parameter int N    = 16,
    parameter int LW   = $clog2(N),
    parameter int FW   = 18,
    parameter int CW   = 16,
    parameter int TOUT = 16,
    localparam int TW  = $clog2(TOUT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  elig,
    input  logic [FW-1:0] cur_adr,
    input  logic [CW-1:0] cur_cnt,
    output logic [LW-1:0] cur_idx,
    output logic          busy,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [FW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [7:0]    mem_rsp_data,
    output logic [N-1:0]  tx_load,
    output logic [7:0]    tx_data,
    output logic          upd,
    output logic [FW-1:0] upd_adr,
    output logic [CW-1:0] upd_cnt,
    output logic          fin,
    output logic          merr
);
    typedef struct packed {
        eng_st_e       st;
        logic [LW-1:0] idx;
        logic [LW-1:0] last;
        logic [TW-1:0] tmr;
    } eng_t;

    eng_t          eng_d, eng_q;
    logic          pick_any;
    logic [LW-1:0] pick_idx;

    txd_rr_pick #(.N(N), .LW(LW)) u_pick (
        .req  (elig),
        .last (eng_q.last),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    always_comb begin
        eng_d   = eng_q;
        upd     = 1'b0;
        fin     = 1'b0;
        merr    = 1'b0;
        upd_adr = cur_adr + FW'(1);
        upd_cnt = cur_cnt + CW'(1);
        unique case (eng_q.st)
            ST_IDLE: begin
                if (pick_any) begin
                    eng_d.idx = pick_idx;
                    eng_d.st  = ST_REQ;
                    eng_d.tmr = '0;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    eng_d.st  = ST_WAIT;
                    eng_d.tmr = '0;
                end else if (eng_q.tmr == TW'(TOUT - 1)) begin
                    merr       = 1'b1;
                    fin        = 1'b1;
                    eng_d.st   = ST_IDLE;
                    eng_d.last = eng_q.idx;
                end else begin
                    eng_d.tmr = eng_q.tmr + TW'(1);
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    upd        = 1'b1;
                    fin        = (upd_cnt == '0);
                    eng_d.st   = ST_IDLE;
                    eng_d.last = eng_q.idx;
                end else if (eng_q.tmr == TW'(TOUT - 1)) begin
                    merr       = 1'b1;
                    fin        = 1'b1;
                    eng_d.st   = ST_IDLE;
                    eng_d.last = eng_q.idx;
                end else begin
                    eng_d.tmr = eng_q.tmr + TW'(1);
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '{st: ST_IDLE, default: '0};
        else        eng_q <= eng_d;
    end

    assign cur_idx       = eng_q.idx;
    assign busy          = (eng_q.st != ST_IDLE);
    assign mem_req_valid = (eng_q.st == ST_REQ);
    assign mem_req_addr  = cur_adr;
    assign tx_data       = mem_rsp_data;
    assign tx_load       = upd ? (N'(1) << eng_q.idx) : '0;
endmodule

// File: rtl/mux_txdma.sv
`timescale 1ns/1ps
module mux_txdma
    import txd_pkg::*;
#(
    parameter int N    = 16,
    parameter int AW   = 16,
    parameter int XW   = 2,
    parameter int CW   = 16,
    parameter int TOUT = 16,
    localparam int LW  = $clog2(N),
    localparam int FW  = AW + XW,
    localparam int RW  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [FW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [7:0]    mem_rsp_data,
    input  logic [N-1:0]  tx_empty,
    output logic [N-1:0]  tx_load,
    output logic [7:0]    tx_data,
    output logic [N-1:0]  tx_break,
    output logic          irq
);
    typedef struct packed {
        logic [LW-1:0] sel;
        logic          ien;
        logic          done;
        logic          merr;
        logic [N-1:0]  act;
        logic [N-1:0]  brk;
    } top_t;

    top_t top_d, top_q;

    logic wr_ctl, wr_adr, wr_cnt, wr_act, wr_brk;
    logic [AW-1:0] sel_adr;
    logic [CW-1:0] sel_cnt;
    logic [XW-1:0] sel_ext;
    logic [FW-1:0] eng_adr, upd_adr;
    logic [CW-1:0] eng_cnt, upd_cnt;
    logic [N-1:0]  cnt_zero, elig, busy_mask, zero_fin, hw_clr;
    logic [LW-1:0] cur_idx;
    logic          busy, upd, fin, merr_evt;

    assign wr_ctl = reg_wr && (reg_addr == OFS_CTL);
    assign wr_adr = reg_wr && (reg_addr == OFS_ADR);
    assign wr_cnt = reg_wr && (reg_addr == OFS_CNT);
    assign wr_act = reg_wr && (reg_addr == OFS_ACT);
    assign wr_brk = reg_wr && (reg_addr == OFS_BRK);

    txd_line_bank #(.N(N), .LW(LW), .AW(AW), .XW(XW), .CW(CW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_sel     (top_q.sel),
        .sw_we_adr  (wr_adr),
        .sw_adr     (AW'(reg_wdata)),
        .sw_we_cnt  (wr_cnt),
        .sw_cnt     (CW'(reg_wdata)),
        .sw_we_ext  (wr_ctl),
        .sw_ext_idx (reg_wdata[LW-1:0]),
        .sw_ext     (reg_wdata[CB_EXT +: XW]),
        .hw_upd     (upd),
        .hw_idx     (cur_idx),
        .hw_adr     (upd_adr),
        .hw_cnt     (upd_cnt),
        .sel_adr    (sel_adr),
        .sel_cnt    (sel_cnt),
        .sel_ext    (sel_ext),
        .eng_adr    (eng_adr),
        .eng_cnt    (eng_cnt),
        .cnt_zero   (cnt_zero)
    );

    assign elig = top_q.act & tx_empty & ~cnt_zero;

    txd_fetch_engine #(.N(N), .LW(LW), .FW(FW), .CW(CW), .TOUT(TOUT)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .elig          (elig),
        .cur_adr       (eng_adr),
        .cur_cnt       (eng_cnt),
        .cur_idx       (cur_idx),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .tx_load       (tx_load),
        .tx_data       (tx_data),
        .upd           (upd),
        .upd_adr       (upd_adr),
        .upd_cnt       (upd_cnt),
        .fin           (fin),
        .merr          (merr_evt)
    );

    assign busy_mask = busy ? (N'(1) << cur_idx) : '0;
    assign zero_fin  = top_q.act & cnt_zero & ~busy_mask;
    assign hw_clr    = zero_fin | (fin ? (N'(1) << cur_idx) : '0);

    always_comb begin
        top_d = top_q;
        if (wr_ctl) begin
            top_d.sel = reg_wdata[LW-1:0];
            top_d.ien = reg_wdata[CB_IEN];
            if (!reg_wdata[CB_DONE]) top_d.done = 1'b0;
            if (reg_wdata[CB_MCLR])  top_d.merr = 1'b0;
        end
        if (wr_brk) top_d.brk = reg_wdata[N-1:0];
        top_d.act = (top_q.act & ~hw_clr) | (wr_act ? reg_wdata[N-1:0] : '0);
        // hardware-set flags win over a same-cycle clear
        if (|hw_clr)  top_d.done = 1'b1;
        if (merr_evt) top_d.merr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTL: begin
                reg_rdata[LW-1:0]       = top_q.sel;
                reg_rdata[CB_EXT +: XW] = sel_ext;
                reg_rdata[CB_IEN]       = top_q.ien;
                reg_rdata[CB_DONE]      = top_q.done;
                reg_rdata[CB_MERR]      = top_q.merr;
            end
            OFS_ADR: reg_rdata = RW'(sel_adr);
            OFS_CNT: reg_rdata = RW'(sel_cnt);
            OFS_ACT: reg_rdata = RW'(top_q.act);
            OFS_BRK: reg_rdata = RW'(top_q.brk);
            default: reg_rdata = '0;
        endcase
    end

    assign tx_break = top_q.brk;
    assign irq      = top_q.done & top_q.ien;

    logic [N-1:0] act_flags;
    logic         done_flag, merr_flag;
    assign act_flags = top_q.act;
    assign done_flag = top_q.done;
    assign merr_flag = top_q.merr;
endmodule

// File: rtl/txd_checker.sv
`timescale 1ns/1ps
module txd_checker
    import txd_pkg::*;
#(
    parameter int N  = 16,
    parameter int FW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [15:0]   reg_wdata,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [FW-1:0] mem_req_addr,
    input logic [N-1:0]  tx_load,
    input logic [N-1:0]  act,
    input logic          done,
    input logic          merr,
    input logic          irq
);
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_load_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load & ~act) == '0);

    p_load_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_load));

    p_req_needs_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (act != '0));

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && !(reg_wr && reg_addr == OFS_CTL && !reg_wdata[CB_DONE]) |=> done);

    p_merr_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        merr && !(reg_wr && reg_addr == OFS_CTL && reg_wdata[CB_MCLR]) |=> merr);

    p_irq_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
endmodule

bind mux_txdma txd_checker #(.N(N), .FW(FW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .tx_load       (tx_load),
    .act           (act_flags),
    .done          (done_flag),
    .merr          (merr_flag),
    .irq           (irq)
);

// File: tb/mux_txdma_tb_top.sv
`timescale 1ns/1ps
module mux_txdma_tb_top;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [17:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;
    logic [N-1:0] tx_empty = '1;
    logic [N-1:0] tx_load;
    logic [7:0]  tx_data;
    logic [N-1:0] tx_break;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    byte unsigned exp_q [N][$];
    int ld_cnt [N];
    int order_log [$];

    mux_txdma dut_i (.*);

    always #5 clk = ~clk;

    function automatic logic [7:0] mdat(input logic [17:0] a);
        return a[7:0] ^ {a[17:16], 6'b0};
    endfunction

    // memory model: answers one cycle after acceptance, no answer above 0x30000
    always @(posedge clk) begin
        if (mem_req_valid && mem_req_ready && mem_req_addr[17:16] != 2'b11) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mdat(mem_req_addr);
        end else begin
            mem_rsp_valid <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops the expected byte for the strobed line
    always @(negedge clk) begin
        if (rst_n && tx_load != '0) begin
            for (int l = 0; l < N; l++) begin
                if (tx_load[l]) begin
                    ld_cnt[l]++;
                    order_log.push_back(l);
                    if (exp_q[l].size() == 0) begin
                        checks++; fails++;
                        $display("FAIL R4: actual load on line %0d expected none", l);
                    end else begin
                        chk("R4", {24'd0, tx_data}, {24'd0, exp_q[l].pop_front()});
                    end
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [15:0] mkctl(input int sel, input int ext, input bit ien,
                                          input bit keep, input bit mclr);
        logic [15:0] w = '0;
        w[3:0] = 4'(sel); w[5:4] = 2'(ext); w[13] = ien; w[15] = keep; w[8] = mclr;
        return w;
    endfunction

    task automatic load_line(input int line, input int ext, input logic [15:0] adr,
                             input int n, input bit push);
        logic [17:0] fa;
        wr(3'd0, mkctl(line, ext, 1'b0, 1'b1, 1'b0));
        wr(3'd1, adr);
        wr(3'd2, 16'(-n));
        if (push)
            for (int k = 0; k < n; k++) begin
                fa = {2'(ext), adr} + 18'(k);
                exp_q[line].push_back(mdat(fa));
            end
    endtask

    task automatic wait_clear(input string req, input logic [15:0] mask);
        logic [15:0] v;
        for (int c = 0; c < 600; c++) begin
            rd(3'd3, v);
            if ((v & mask) == 0) return;
        end
        chk(req, {16'd0, v & mask}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1", {16'd0, v}, 32'd0);
        end
        chk("R1", {31'd0, irq}, 0);
        chk("R1", {31'd0, mem_req_valid}, 0);
        chk("R1", {16'd0, tx_break}, 0);

        // R2 banked window
        load_line(3, 1, 16'h1000, 4, 1'b1);
        load_line(5, 0, 16'h2000, 2, 1'b0);
        wr(3'd0, mkctl(3, 1, 1'b0, 1'b1, 1'b0));
        rd(3'd1, v); chk("R2", {16'd0, v}, 32'h1000);
        rd(3'd2, v); chk("R2", {16'd0, v}, 32'hFFFC);
        // R3 high address bits readback
        rd(3'd0, v); chk("R3", {30'd0, v[5:4]}, 1);
        wr(3'd0, mkctl(5, 0, 1'b0, 1'b1, 1'b0));
        rd(3'd1, v); chk("R2", {16'd0, v}, 32'h2000);
        wr(3'd2, 16'h0000);

        // R4/R5 one line, four bytes
        wr(3'd3, 16'h0008);
        wait_clear("R5", 16'h0008);
        wr(3'd0, mkctl(3, 1, 1'b0, 1'b1, 1'b0));
        rd(3'd1, v); chk("R4", {16'd0, v}, 32'h1004);
        rd(3'd2, v); chk("R4", {16'd0, v}, 32'h0000);
        rd(3'd0, v); chk("R5", {31'd0, v[15]}, 1);
        chk("R6", {31'd0, irq}, 0);

        // R6/R7 enable and clear
        wr(3'd0, mkctl(3, 1, 1'b1, 1'b1, 1'b0));
        #1 chk("R6", {31'd0, irq}, 1);
        wr(3'd0, mkctl(3, 1, 1'b1, 1'b0, 1'b0));
        rd(3'd0, v); chk("R7", {31'd0, v[15]}, 0);
        chk("R6", {31'd0, irq}, 0);
        wr(3'd0, mkctl(3, 1, 1'b0, 1'b1, 1'b0));
        rd(3'd0, v); chk("R7", {31'd0, v[15]}, 0);

        // R8 rotating service between lines 1 and 2
        load_line(1, 0, 16'h0100, 3, 1'b1);
        load_line(2, 0, 16'h0200, 3, 1'b1);
        order_log.delete();
        wr(3'd3, 16'h0006);
        wait_clear("R8", 16'h0006);
        chk("R8", order_log.size(), 6);
        for (int k = 1; k < order_log.size(); k++)
            chk("R8", {31'd0, order_log[k] == order_log[k-1]}, 0);

        // R8 full serialiser holds a line off; R10 zero bits ignored
        tx_empty[6] = 1'b0;
        load_line(6, 0, 16'h0600, 1, 1'b1);
        wr(3'd3, 16'h0040);
        repeat (40) @(negedge clk);
        chk("R8", ld_cnt[6], 0);
        wr(3'd3, 16'h0000);
        rd(3'd3, v); chk("R10", {16'd0, v}, 32'h0040);
        tx_empty[6] = 1'b1;
        wait_clear("R8", 16'h0040);
        chk("R8", ld_cnt[6], 1);

        // R9 stop a running line
        load_line(7, 0, 16'h0700, 10, 1'b0);
        for (int k = 0; k < 3; k++) exp_q[7].push_back(mdat(18'h00700 + 18'(k)));
        wr(3'd3, 16'h0080);
        for (int c = 0; c < 200 && ld_cnt[7] < 2; c++) begin
            @(negedge clk); #1;
        end
        tx_empty[7] = 1'b0;
        wr(3'd0, mkctl(7, 0, 1'b0, 1'b1, 1'b0));
        wr(3'd2, 16'hFFFF);
        tx_empty[7] = 1'b1;
        wait_clear("R9", 16'h0080);
        chk("R9", ld_cnt[7], 3);
        rd(3'd1, v); chk("R9", {16'd0, v}, 32'h0703);

        // R11 zero count finishes at once
        wr(3'd0, mkctl(9, 0, 1'b0, 1'b0, 1'b0));
        wr(3'd3, 16'h0200);
        rd(3'd3, v); chk("R11", {16'd0, v}, 0);
        rd(3'd0, v); chk("R11", {31'd0, v[15]}, 1);
        chk("R11", ld_cnt[9], 0);

        // R3 carry into the high bits
        load_line(11, 0, 16'hFFFF, 2, 1'b1);
        wr(3'd3, 16'h0800);
        wait_clear("R3", 16'h0800);
        wr(3'd0, mkctl(11, 0, 1'b0, 1'b1, 1'b0));
        rd(3'd0, v); chk("R3", {30'd0, v[5:4]}, 0);
        // a control write rewrote the high bits, so re-read after reloading them
        wr(3'd0, mkctl(11, 1, 1'b0, 1'b1, 1'b0));
        rd(3'd1, v); chk("R3", {16'd0, v}, 32'h0001);

        // R12 memory error
        wr(3'd0, mkctl(10, 3, 1'b0, 1'b0, 1'b0));
        load_line(10, 3, 16'h0050, 2, 1'b0);
        wr(3'd3, 16'h0400);
        wait_clear("R12", 16'h0400);
        rd(3'd0, v);
        chk("R12", {31'd0, v[10]}, 1);
        chk("R12", {31'd0, v[15]}, 1);
        rd(3'd1, v); chk("R12", {16'd0, v}, 32'h0050);
        rd(3'd2, v); chk("R12", {16'd0, v}, 32'hFFFE);
        wr(3'd0, mkctl(10, 3, 1'b0, 1'b1, 1'b1));
        rd(3'd0, v); chk("R12", {31'd0, v[10]}, 0);

        // R13 break
        wr(3'd4, 16'h8001);
        #1 chk("R13", {16'd0, tx_break}, 32'h8001);
        rd(3'd4, v); chk("R13", {16'd0, v}, 32'h8001);

        for (int l = 0; l < N; l++) chk("R4", exp_q[l].size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule